// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Controller

This block guards a synchronous buck power stage against overload. Every switching cycle it applies a current limit. If the high-side current comparator trips, the high-side switch is forced off at once and stays off until the next cycle begins. The low-side switch is forced on until the inductor current has dropped below the low-side limit.

A sustained short is told apart from a brief overload by time. Feedback must sit below 70 % of the reference, while the limit is active, for a full blanking interval measured on a microsecond timebase. Only then is the stage shut down.

Once shut down, both switches stay off and the compensation node and reference are pulled low for a fixed number of switching cycles. A restart is then attempted. During a startup window the low-feedback flag is not acted upon. At the end of that window the flag is sampled: the controller either resumes normal operation or goes back into the off state.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: `hs_off` is high in every cycle where `hs_oc` is high, and once high it stays high until a cycle in which `sw_tick` is high and `hs_oc` is low (or `en` is low).
- R2: `ls_on` goes high in the cycle `hs_oc` is high and stays high until a cycle in which `ls_below` is high and `hs_oc` is low; the hold is dropped when `en` is low or the stage is shut down.
- R3: The stage shuts down (`sw_dis` high from the next cycle) once `fb_low` has been high and the limit active (`hs_oc` or the low-side hold) in every cycle spanning BLANK_US consecutive `us_tick` pulses (default 12) while in normal operation.
- R4: Any cycle with `fb_low` low or the limit inactive restarts the blanking count from zero, so shorter qualified stretches never shut the stage down.
- R5: While shut down, `sw_dis` and `pull_low` are high, `hs_off` is high and `ls_on` is low, whatever `hs_oc` does.
- R6: The shutdown lasts exactly OFF_CYC `sw_tick` pulses (default 896); `sw_dis` falls in the cycle after the last of them.
- R7: During the restart window of RETRY_CYC `sw_tick` pulses (default 112), `fb_low` is ignored: `sw_dis` and `pull_low` stay low, while the per-cycle limit of R1 and R2 keeps working.
- R8: On the last `sw_tick` of the restart window, `fb_low` high sends the controller back into shutdown (`sw_dis` high next cycle); `fb_low` low returns it to normal operation.
- R9: `en` low, or `rst_n` low, clears the controller to normal operation with all counters and holds at zero; afterwards a full blanking interval is needed again before shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low clears the controller synchronously |
| hs_oc | input | 1 | High-side current above peak limit |
| ls_below | input | 1 | Low-side current has fallen below its limit |
| fb_low | input | 1 | Feedback below 70 % of reference |
| sw_tick | input | 1 | One-clock pulse at each switching-cycle start |
| us_tick | input | 1 | One-clock pulse per microsecond |
| hs_off | output | 1 | Force high-side switch off |
| ls_on | output | 1 | Force low-side switch on |
| sw_dis | output | 1 | Disable both switches (shutdown) |
| pull_low | output | 1 | Pull compensation node and reference low |

## Verification
The patterns are:
- An isolated limit pulse, with `ls_below` arriving later. This separates the rest-of-cycle high-side block from the low-side hold.
- A qualified stretch one microsecond short of the blanking time, broken by a feedback recovery. This separates a timer that restarts from one that only pauses.
- A full stretch, which must shut the stage down. Here the off length is measured in switching ticks.
- A restart window with `fb_low` held high through most of it and released just before its end, next to one where `fb_low` stays high throughout. This shows that the flag is sampled only at the window's close.
- A disable issued in mid-shutdown, which must return the controller to a clean normal state.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    HC_RUN   = 2'd0,
    HC_OFF   = 2'd1,
    HC_RETRY = 2'd2
  } hc_state_e;

  // true when a counter holding cnt is about to complete lim events
  function automatic logic hits_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

endpackage

// File: rtl/ocp_cycle_limit.sv
module ocp_cycle_limit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic dis,
  input  logic hs_oc,
  input  logic ls_below,
  input  logic sw_tick,
  output logic hs_off,
  output logic ls_on,
  output logic lim_act
);

  logic hs_blk_q;
  logic ls_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_blk_q  <= 1'b0;
      ls_hold_q <= 1'b0;
    end else if (clr) begin
      hs_blk_q  <= 1'b0;
      ls_hold_q <= 1'b0;
    end else begin
      if (hs_oc)        hs_blk_q <= 1'b1;
      else if (sw_tick) hs_blk_q <= 1'b0;
      if (hs_oc)         ls_hold_q <= 1'b1;
      else if (ls_below) ls_hold_q <= 1'b0;
    end
  end

  assign hs_off  = dis | hs_oc | hs_blk_q;
  assign ls_on   = ~dis & (hs_oc | ls_hold_q);
  assign lim_act = hs_oc | ls_hold_q;

endmodule

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int unsigned BLANK_US = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic us_tick,
  output logic trip
);
  import ocp_pkg::*;

  localparam int unsigned BW = $clog2(BLANK_US + 1);

  logic [BW-1:0] cnt_q;
  logic          last_w;

  assign last_w = hits_last(32'(cnt_q), BLANK_US);
  assign trip   = arm & us_tick & last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm) begin
      cnt_q <= '0;
    end else if (us_tick) begin
      cnt_q <= last_w ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq #(
  parameter int unsigned OFF_CYC   = 896,
  parameter int unsigned RETRY_CYC = 112
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               trip,
  input  logic               sw_tick,
  input  logic               fb_low,
  output ocp_pkg::hc_state_e state
);
  import ocp_pkg::*;

  localparam int unsigned MAXC = (OFF_CYC > RETRY_CYC) ? OFF_CYC : RETRY_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  hc_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          off_end;
  logic          retry_end;

  assign off_end   = sw_tick & hits_last(32'(cnt_q), OFF_CYC);
  assign retry_end = sw_tick & hits_last(32'(cnt_q), RETRY_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HC_RUN;
      cnt_q <= '0;
    end else if (!en) begin
      st_q  <= HC_RUN;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        HC_RUN: begin
          cnt_q <= '0;
          if (trip) st_q <= HC_OFF;
        end
        HC_OFF: begin
          if (off_end) begin
            st_q  <= HC_RETRY;
            cnt_q <= '0;
          end else if (sw_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HC_RETRY: begin
          if (retry_end) begin
            st_q  <= fb_low ? HC_OFF : HC_RUN;
            cnt_q <= '0;
          end else if (sw_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= HC_RUN;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign state = st_q;

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int unsigned BLANK_US  = 12,
  parameter int unsigned OFF_CYC   = 896,
  parameter int unsigned RETRY_CYC = 112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hs_oc,
  input  logic ls_below,
  input  logic fb_low,
  input  logic sw_tick,
  input  logic us_tick,
  output logic hs_off,
  output logic ls_on,
  output logic sw_dis,
  output logic pull_low
);
  import ocp_pkg::*;

  hc_state_e state_w;
  logic      in_off_w;
  logic      in_run_w;
  logic      lim_act_w;
  logic      arm_w;
  logic      trip_w;
  logic      clr_w;

  assign in_off_w = (state_w == HC_OFF);
  assign in_run_w = (state_w == HC_RUN);
  assign clr_w    = ~en | in_off_w;
  assign arm_w    = en & in_run_w & lim_act_w & fb_low;

  ocp_cycle_limit u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .dis      (in_off_w),
    .hs_oc    (hs_oc),
    .ls_below (ls_below),
    .sw_tick  (sw_tick),
    .hs_off   (hs_off),
    .ls_on    (ls_on),
    .lim_act  (lim_act_w)
  );

  ocp_blank_timer #(.BLANK_US(BLANK_US)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm_w),
    .us_tick (us_tick),
    .trip    (trip_w)
  );

  ocp_hiccup_seq #(.OFF_CYC(OFF_CYC), .RETRY_CYC(RETRY_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .trip    (trip_w),
    .sw_tick (sw_tick),
    .fb_low  (fb_low),
    .state   (state_w)
  );

  assign sw_dis   = in_off_w;
  assign pull_low = in_off_w;

endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
  parameter int unsigned OFF_CYC = 896
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic hs_oc,
  input logic ls_below,
  input logic sw_tick,
  input logic hs_off,
  input logic ls_on,
  input logic sw_dis,
  input logic pull_low,
  input logic trip
);

  int unsigned off_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_ticks <= 0;
    else if (!sw_dis) off_ticks <= 0;
    else if (sw_tick) off_ticks <= off_ticks + 1;
  end

  p_hs_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_oc |-> hs_off);

  p_hs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_off && en && !sw_tick) |=> hs_off);

  p_ls_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && !ls_below && en) |=> (ls_on || sw_dis));

  p_trip_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> sw_dis);

  p_off_outs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_dis |-> (pull_low && hs_off && !ls_on));

  p_off_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_dis) && $past(en)) |-> (off_ticks == OFF_CYC));

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(.OFF_CYC(OFF_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .hs_oc    (hs_oc),
  .ls_below (ls_below),
  .sw_tick  (sw_tick),
  .hs_off   (hs_off),
  .ls_on    (ls_on),
  .sw_dis   (sw_dis),
  .pull_low (pull_low),
  .trip     (trip_w)
);

// File: tb/ocp_hiccup_ctrl_tb.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_tb;

  localparam int BLANK = 12;
  localparam int OFFC  = 896;
  localparam int RETC  = 112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, hs_oc = 1'b0, ls_below = 1'b0, fb_low = 1'b0;
  logic sw_tick = 1'b0, us_tick = 1'b0;
  logic hs_off, ls_on, sw_dis, pull_low;

  always #10 clk = ~clk;

  ocp_hiccup_ctrl #(.BLANK_US(BLANK), .OFF_CYC(OFFC), .RETRY_CYC(RETC)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .hs_oc(hs_oc), .ls_below(ls_below),
    .fb_low(fb_low), .sw_tick(sw_tick), .us_tick(us_tick),
    .hs_off(hs_off), .ls_on(ls_on), .sw_dis(sw_dis), .pull_low(pull_low));

  int total = 0, bad = 0;
  int cyc = 0;
  bit n_en = 0, n_oc = 0, n_below = 0, n_fbl = 0;
  bit modeled = 0;
  // reference model: mode 0 normal, 1 shut down, 2 restart window
  int m_mode = 0, m_cnt = 0, m_blank = 0;
  bit m_hsb = 0, m_lsh = 0;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit off, e_hs, e_ls, arm, trip;
    @(negedge clk);
    en = n_en; hs_oc = n_oc; ls_below = n_below; fb_low = n_fbl;
    sw_tick = (cyc % 2) == 1;
    us_tick = (cyc % 3) == 2;
    cyc++;
    #1;
    off  = (m_mode == 1);
    e_hs = off || hs_oc || m_hsb;
    e_ls = !off && (hs_oc || m_lsh);
    if (modeled) begin
      check("R1 hs_off", hs_off, e_hs);
      check("R2 ls_on", ls_on, e_ls);
      check("R5 sw_dis", sw_dis, off);
      check("R5 pull_low", pull_low, off);
    end
    @(posedge clk);
    if (!modeled) return;
    arm  = en && m_mode == 0 && (hs_oc || m_lsh) && fb_low;
    trip = arm && us_tick && (m_blank == BLANK - 1);
    if (!en || off) begin
      m_hsb = 0; m_lsh = 0;
    end else begin
      if (hs_oc) m_hsb = 1; else if (sw_tick) m_hsb = 0;
      if (hs_oc) m_lsh = 1; else if (ls_below) m_lsh = 0;
    end
    if (!arm) m_blank = 0;
    else if (us_tick) m_blank = trip ? 0 : m_blank + 1;
    if (!en) begin
      m_mode = 0; m_cnt = 0;
    end else if (m_mode == 0) begin
      if (trip) begin m_mode = 1; m_cnt = 0; end
    end else if (sw_tick) begin
      m_cnt++;
      if (m_mode == 1 && m_cnt == OFFC) begin m_mode = 2; m_cnt = 0; end
      else if (m_mode == 2 && m_cnt == RETC) begin m_mode = fb_low ? 1 : 0; m_cnt = 0; end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // wait for shutdown; returns cycles waited
  task automatic until_off(output int waited);
    waited = 0;
    while (!sw_dis && waited < 200) begin step(); waited++; end
  endtask

  int w, ticks;

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run(3);
    #2;
    // reset state
    check("R9 reset hs_off", hs_off, 1'b0);
    check("R9 reset ls_on", ls_on, 1'b0);
    check("R9 reset sw_dis", sw_dis, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    modeled = 1; n_en = 1;
    run(4);

    // R1/R2: single limit event, low-side held until ls_below
    n_oc = 1; step(); n_oc = 0;
    run(3);
    check("R2 hold", ls_on, 1'b1);
    n_below = 1; step(); n_below = 0; step();
    check("R2 release", ls_on, 1'b0);
    check("R1 released after tick", hs_off, 1'b0);

    // R4: qualified stretch broken before blanking ends
    n_oc = 1; step(); n_oc = 0; n_fbl = 1;
    run(3 * (BLANK - 1) - 2);
    n_fbl = 0; step(); n_fbl = 1;
    run(3 * (BLANK - 1));
    check("R4 no shutdown", sw_dis, 1'b0);
    n_fbl = 0; n_below = 1; run(2); n_below = 0;

    // R3: full stretch shuts down
    n_oc = 1; step(); n_oc = 0; n_fbl = 1;
    until_off(w);
    check("R3 shutdown reached", sw_dis, 1'b1);
    check("R3 not early", (w >= 3 * (BLANK - 1)), 1'b1);
    // R5 + R6: hs_oc ignored, count off ticks
    ticks = 0;
    n_oc = 1;
    while (sw_dis && ticks < 2000) begin
      if (sw_tick) ticks++;
      check("R5 ls_on off", ls_on, 1'b0);
      step();
    end
    n_oc = 0;
    check("R6 off length", (ticks == OFFC), 1'b1);
    // R7: fb_low held high most of the restart window
    run(2 * RETC - 10);
    check("R7 ignored fb_low", sw_dis, 1'b0);
    check("R7 no pull", pull_low, 1'b0);
    n_fbl = 0;
    run(20);
    check("R8 resumed", sw_dis, 1'b0);

    // R8: fault persists -> back to shutdown
    n_oc = 1; step(); n_oc = 0; n_fbl = 1;
    until_off(w);
    while (sw_dis) step();
    run(2 * RETC + 4);
    check("R8 re-entered", sw_dis, 1'b1);

    // R9: disable mid-shutdown
    run(50);
    n_en = 0; run(2);
    check("R9 cleared", sw_dis, 1'b0);
    n_en = 1; n_fbl = 0; run(2);
    n_oc = 1; step(); n_oc = 0; n_fbl = 1;
    run(3 * (BLANK - 2));
    check("R9 full blank needed", sw_dis, 1'b0);
    until_off(w);
    check("R9 then shutdown", sw_dis, 1'b1);
    n_en = 0; n_fbl = 0; run(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule